// File: doc/BRIEF.md
# Remote page read responder

This block sits on the serving side of a card-to-card memory link used to move a migrating process's pages on demand. A peer card sends a page read request that names a virtual address, a cluster-wide address space number, a page count and a sequence tag. The block translates the cluster-wide number into the card-local address space number through a small table, then fetches the pages from host memory by virtual address. Every fetched 64-byte beat goes back to the requester with the request's sequence tag.

Software fills and clears the table through a plain write port when a process joins or leaves a migration. A request whose address space number is not in the table, a request for zero pages, or a request carrying the write opcode gets a single-beat error response and starts no memory access. The block handles one request at a time. It keeps one memory read outstanding and forwards each beat before it fetches the next one.

Top module: `page_read_responder`

## Requirements
- R1: `req_ready_o` is high only when no request is in progress. It falls in the cycle after a header is accepted and rises again only after the handshake on the response beat that has `rsp_last_o` set.
- R2: When the cluster ID of a read request matches a valid table entry, every memory read for that request carries the entry's local ID on `dma_lid_o`. The lookup takes one cycle: in the cycle after acceptance neither `dma_req_valid_o` nor `rsp_valid_o` is high, and in the next cycle one of them is high.
- R3: A table write with `tbl_we_i` high replaces entry `tbl_idx_i` with the given valid bit, cluster ID and local ID. Writing the valid bit as 0 removes the mapping. If two valid entries hold the same cluster ID, the entry with the lower index wins.
- R4: Beat k of a request is read from `req_vaddr_i + 64*k`, so beat 0 uses the requested address unchanged. At most one memory read is outstanding. A read request keeps its address stable until `dma_req_ready_i` is high.
- R5: A successful request returns exactly npages*64 beats with status 2'b00, in address order. Each beat carries the memory data for its address. `rsp_last_o` is set on the final beat only.
- R6: Every response beat, error or not, carries the sequence tag of the request on `rsp_seq_o`.
- R7: A request with `req_write_i` = 1 gets one beat with status 2'b10, `rsp_last_o` = 1 and zero data, and issues no memory read.
- R8: A read request whose cluster ID matches no valid entry gets one beat with status 2'b01, `rsp_last_o` = 1 and zero data, and issues no memory read.
- R9: A read request with page count 0 gets one beat with status 2'b11 and issues no memory read. The checks run in this order: the write opcode first, then the zero count, then the table miss.
- R10: While `rsp_valid_o` is high and `rsp_ready_i` is low, every response output holds its value.
- R11: After reset, `req_ready_o` = 1, `rsp_valid_o` = 0, `dma_req_valid_o` = 0, and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | IDX_W | Entry index to write |
| tbl_valid_i | input | 1 | Valid bit to store |
| tbl_gid_i | input | GID_W | Cluster-wide address space ID |
| tbl_lid_i | input | LID_W | Card-local address space ID |
| req_valid_i | input | 1 | Request header valid |
| req_ready_o | output | 1 | Block idle, header accepted |
| req_write_i | input | 1 | Opcode, 1 = write (rejected) |
| req_vaddr_i | input | VA_W | Virtual address of the first page |
| req_gid_i | input | GID_W | Cluster-wide ID of the request |
| req_npages_i | input | NP_W | Number of pages |
| req_seq_i | input | SEQ_W | Request sequence tag |
| dma_req_valid_o | output | 1 | Memory read request |
| dma_req_ready_i | input | 1 | Memory read accepted |
| dma_addr_o | output | VA_W | Virtual address of the beat |
| dma_lid_o | output | LID_W | Local address space ID |
| dma_rsp_valid_i | input | 1 | Read data returned |
| dma_rsp_data_i | input | BEAT_W | Read data beat |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_ready_i | input | 1 | Response beat taken |
| rsp_status_o | output | 2 | 00 ok, 01 unmapped, 10 write, 11 zero count |
| rsp_seq_o | output | SEQ_W | Echoed sequence tag |
| rsp_last_o | output | 1 | Final beat of the response |
| rsp_data_o | output | BEAT_W | Page data beat |

## Verification
The assertions rest on three assumptions about the environment. The memory port returns exactly one data beat for each accepted read, and only while the block is waiting for it. Table writes never coincide with a lookup. `req_valid_i` is only raised for a fresh request. The bench's memory model answers each handshake once after a chosen latency and stays silent otherwise. The bench touches the table only between requests and raises a header only once the previous response has drained. Randomized ready and latency then vary the handshake timing without leaving these bounds.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_NO_MAP  = 2'b01,
    ST_BAD_OP  = 2'b10,
    ST_BAD_LEN = 2'b11
  } rsp_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_DMA_REQ, S_DMA_WAIT, S_SEND, S_ERR
  } state_e;
endpackage

// File: rtl/rpr_xlate_table.sv
module rpr_xlate_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned GID_W   = 8,
  parameter int unsigned LID_W   = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             valid_i,
  input  logic [GID_W-1:0] gid_i,
  input  logic [LID_W-1:0] lid_i,
  input  logic [GID_W-1:0] key_i,
  output logic             hit_o,
  output logic [LID_W-1:0] lid_o
);
  logic [ENTRIES-1:0]  vld_q;
  logic [GID_W-1:0]    gid_q [ENTRIES];
  logic [LID_W-1:0]    lid_q [ENTRIES];
  logic [ENTRIES-1:0]  match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        gid_q[i] <= '0;
        lid_q[i] <= '0;
      end else if (we_i && idx_i == IDX_W'(i)) begin
        vld_q[i] <= valid_i;
        gid_q[i] <= gid_i;
        lid_q[i] <= lid_i;
      end
    end
    assign match[i] = vld_q[i] && (gid_q[i] == key_i);
  end

  // lowest index wins on duplicates
  always_comb begin
    hit_o = 1'b0;
    lid_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        lid_o = lid_q[i];
      end
    end
  end
endmodule

// File: rtl/rpr_beat_addr.sv
module rpr_beat_addr #(
  parameter int unsigned VA_W    = 48,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned BEAT_SH = 6
) (
  input  logic [VA_W-1:0]  base_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] total_i,
  output logic [VA_W-1:0]  addr_o,
  output logic             last_o
);
  assign addr_o = base_i + (VA_W'(cnt_i) << BEAT_SH);
  assign last_o = (cnt_i == total_i - CNT_W'(1));
endmodule

// File: rtl/page_read_responder.sv
module page_read_responder
  import rpr_pkg::*;
#(
  parameter int unsigned VA_W       = 48,
  parameter int unsigned GID_W      = 8,
  parameter int unsigned LID_W      = 8,
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned NP_W       = 4,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned BEAT_BYTES = 64,
  parameter int unsigned IDX_W      = $clog2(ENTRIES),
  parameter int unsigned BEAT_W     = BEAT_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  input  logic              tbl_valid_i,
  input  logic [GID_W-1:0]  tbl_gid_i,
  input  logic [LID_W-1:0]  tbl_lid_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [GID_W-1:0]  req_gid_i,
  input  logic [NP_W-1:0]   req_npages_i,
  input  logic [SEQ_W-1:0]  req_seq_i,
  output logic              dma_req_valid_o,
  input  logic              dma_req_ready_i,
  output logic [VA_W-1:0]   dma_addr_o,
  output logic [LID_W-1:0]  dma_lid_o,
  input  logic              dma_rsp_valid_i,
  input  logic [BEAT_W-1:0] dma_rsp_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_status_o,
  output logic [SEQ_W-1:0]  rsp_seq_o,
  output logic              rsp_last_o,
  output logic [BEAT_W-1:0] rsp_data_o
);
  localparam int unsigned BPP     = PAGE_BYTES / BEAT_BYTES;
  localparam int unsigned PG_SH   = $clog2(BPP);
  localparam int unsigned BEAT_SH = $clog2(BEAT_BYTES);
  localparam int unsigned CNT_W   = NP_W + PG_SH;

  state_e            state_q;
  rsp_status_e       status_q;
  logic              write_q;
  logic [VA_W-1:0]   vaddr_q;
  logic [GID_W-1:0]  gid_q;
  logic [NP_W-1:0]   np_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [LID_W-1:0]  lid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BEAT_W-1:0] data_q;

  logic              tbl_hit;
  logic [LID_W-1:0]  tbl_lid;
  logic [CNT_W-1:0]  total;
  logic              beat_last;

  rpr_xlate_table #(
    .ENTRIES(ENTRIES), .GID_W(GID_W), .LID_W(LID_W), .IDX_W(IDX_W)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .idx_i   (tbl_idx_i),
    .valid_i (tbl_valid_i),
    .gid_i   (tbl_gid_i),
    .lid_i   (tbl_lid_i),
    .key_i   (gid_q),
    .hit_o   (tbl_hit),
    .lid_o   (tbl_lid)
  );

  assign total = CNT_W'(np_q) << PG_SH;

  rpr_beat_addr #(
    .VA_W(VA_W), .CNT_W(CNT_W), .BEAT_SH(BEAT_SH)
  ) u_addr (
    .base_i  (vaddr_q),
    .cnt_i   (cnt_q),
    .total_i (total),
    .addr_o  (dma_addr_o),
    .last_o  (beat_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      write_q  <= 1'b0;
      vaddr_q  <= '0;
      gid_q    <= '0;
      np_q     <= '0;
      seq_q    <= '0;
      lid_q    <= '0;
      cnt_q    <= '0;
      data_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          write_q <= req_write_i;
          vaddr_q <= req_vaddr_i;
          gid_q   <= req_gid_i;
          np_q    <= req_npages_i;
          seq_q   <= req_seq_i;
          state_q <= S_LOOKUP;
        end
        S_LOOKUP: begin
          cnt_q <= '0;
          lid_q <= tbl_lid;
          if (write_q) begin
            status_q <= ST_BAD_OP;
            state_q  <= S_ERR;
          end else if (np_q == '0) begin
            status_q <= ST_BAD_LEN;
            state_q  <= S_ERR;
          end else if (!tbl_hit) begin
            status_q <= ST_NO_MAP;
            state_q  <= S_ERR;
          end else begin
            status_q <= ST_OK;
            state_q  <= S_DMA_REQ;
          end
        end
        S_DMA_REQ: if (dma_req_ready_i) state_q <= S_DMA_WAIT;
        S_DMA_WAIT: if (dma_rsp_valid_i) begin
          data_q  <= dma_rsp_data_i;
          state_q <= S_SEND;
        end
        S_SEND: if (rsp_ready_i) begin
          if (beat_last) begin
            state_q <= S_IDLE;
          end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            state_q <= S_DMA_REQ;
          end
        end
        S_ERR: if (rsp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign dma_req_valid_o = (state_q == S_DMA_REQ);
  assign dma_lid_o       = lid_q;
  assign rsp_valid_o     = (state_q == S_SEND) || (state_q == S_ERR);
  assign rsp_status_o    = (state_q == S_ERR) ? status_q : ST_OK;
  assign rsp_seq_o       = seq_q;
  assign rsp_last_o      = (state_q == S_ERR) ? 1'b1 : beat_last;
  assign rsp_data_o      = (state_q == S_SEND) ? data_q : '0;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
  parameter int unsigned VA_W       = 48,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned BEAT_BYTES = 64,
  parameter int unsigned BEAT_W     = BEAT_BYTES * 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [VA_W-1:0]   req_vaddr_i,
  input logic [SEQ_W-1:0]  req_seq_i,
  input logic              dma_req_valid_o,
  input logic              dma_req_ready_i,
  input logic [VA_W-1:0]   dma_addr_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [1:0]        rsp_status_o,
  input logic [SEQ_W-1:0]  rsp_seq_o,
  input logic              rsp_last_o,
  input logic [BEAT_W-1:0] rsp_data_o
);
  localparam int unsigned BEAT_SH = $clog2(BEAT_BYTES);

  logic [VA_W-1:0]  vaddr_r;
  logic [SEQ_W-1:0] seq_r;
  logic [31:0]      beats_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_r <= '0;
      seq_r   <= '0;
      beats_r <= '0;
    end else if (req_valid_i && req_ready_o) begin
      vaddr_r <= req_vaddr_i;
      seq_r   <= req_seq_i;
      beats_r <= '0;
    end else if (dma_req_valid_o && dma_req_ready_i) begin
      beats_r <= beats_r + 32'd1;
    end
  end

  assert_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_lookup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!dma_req_valid_o && !rsp_valid_o) ##1 (dma_req_valid_o || rsp_valid_o));

  assert_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_valid_o |-> dma_addr_o == vaddr_r + (VA_W'(beats_r) << BEAT_SH));

  assert_one_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_valid_o && dma_req_ready_i) |=> !dma_req_valid_o);

  assert_seq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_seq_o == seq_r);

  // covers R7, R8, R9: error beats are single, empty, with no prior read
  assert_err_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != 2'b00) |-> (rsp_last_o && rsp_data_o == '0 && beats_r == 0));

  assert_rsp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o)
                                       && $stable(rsp_status_o) && $stable(rsp_seq_o)));

  assert_dma_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_valid_o && !dma_req_ready_i) |=> (dma_req_valid_o && $stable(dma_addr_o)));
endmodule

bind page_read_responder rpr_checker #(
  .VA_W(VA_W), .SEQ_W(SEQ_W), .BEAT_BYTES(BEAT_BYTES), .BEAT_W(BEAT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_vaddr_i     (req_vaddr_i),
  .req_seq_i       (req_seq_i),
  .dma_req_valid_o (dma_req_valid_o),
  .dma_req_ready_i (dma_req_ready_i),
  .dma_addr_o      (dma_addr_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_status_o    (rsp_status_o),
  .rsp_seq_o       (rsp_seq_o),
  .rsp_last_o      (rsp_last_o),
  .rsp_data_o      (rsp_data_o)
);

// File: tb/page_read_responder_tb_top.sv
module page_read_responder_tb_top;
  localparam int VA_W = 48, GID_W = 8, LID_W = 8, SEQ_W = 16, NP_W = 4;
  localparam int IDX_W = 4, BEAT_W = 512, BPP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              tbl_we = 0, tbl_valid = 0;
  logic [IDX_W-1:0]  tbl_idx = '0;
  logic [GID_W-1:0]  tbl_gid = '0;
  logic [LID_W-1:0]  tbl_lid = '0;
  logic              req_valid = 0, req_write = 0;
  logic              req_ready;
  logic [VA_W-1:0]   req_vaddr = '0;
  logic [GID_W-1:0]  req_gid = '0;
  logic [NP_W-1:0]   req_np = '0;
  logic [SEQ_W-1:0]  req_seq = '0;
  logic              dma_req_valid, dma_req_ready, dma_rsp_valid;
  logic [VA_W-1:0]   dma_addr;
  logic [LID_W-1:0]  dma_lid;
  logic [BEAT_W-1:0] dma_rsp_data;
  logic              rsp_valid, rsp_ready = 0, rsp_last;
  logic [1:0]        rsp_status;
  logic [SEQ_W-1:0]  rsp_seq;
  logic [BEAT_W-1:0] rsp_data;

  int total = 0, bad = 0, dma_cnt = 0;
  bit slow_mem = 0, bp_mode = 0, done = 0;

  page_read_responder dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_valid_i(tbl_valid),
    .tbl_gid_i(tbl_gid), .tbl_lid_i(tbl_lid),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_vaddr_i(req_vaddr), .req_gid_i(req_gid), .req_npages_i(req_np), .req_seq_i(req_seq),
    .dma_req_valid_o(dma_req_valid), .dma_req_ready_i(dma_req_ready),
    .dma_addr_o(dma_addr), .dma_lid_o(dma_lid),
    .dma_rsp_valid_i(dma_rsp_valid), .dma_rsp_data_i(dma_rsp_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_status_o(rsp_status),
    .rsp_seq_o(rsp_seq), .rsp_last_o(rsp_last), .rsp_data_o(rsp_data)
  );

  function automatic logic [BEAT_W-1:0] mk_data(logic [VA_W-1:0] a, logic [LID_W-1:0] l);
    return {8'h0, l, 48'h0, {8{l, a}}};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // host memory model: one read at a time, fixed or random latency
  initial begin
    logic [VA_W-1:0]  a;
    logic [LID_W-1:0] l;
    dma_req_ready = 0; dma_rsp_valid = 0; dma_rsp_data = '0;
    forever begin
      @(negedge clk);
      dma_rsp_valid = 0;
      dma_req_ready = slow_mem ? 1'($urandom % 2) : 1'b1;
      if (dma_req_valid && dma_req_ready) begin
        a = dma_addr; l = dma_lid; dma_cnt++;
        @(negedge clk);
        dma_req_ready = 0;
        repeat (slow_mem ? int'($urandom % 4) : 0) @(negedge clk);
        dma_rsp_valid = 1;
        dma_rsp_data  = mk_data(a, l);
      end
    end
  end

  task automatic tbl_write(int idx, bit v, logic [GID_W-1:0] g, logic [LID_W-1:0] l);
    @(negedge clk);
    tbl_we = 1; tbl_idx = IDX_W'(idx); tbl_valid = v; tbl_gid = g; tbl_lid = l;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // send one request, drain and check its whole response
  task automatic run_req(string req, bit wr, logic [VA_W-1:0] va, logic [GID_W-1:0] g,
                         int np, logic [SEQ_W-1:0] seq, logic [1:0] exp_st, logic [LID_W-1:0] exp_lid);
    int exp_beats = (exp_st == 2'b00) ? np * BPP : 1;
    int d0, k, guard, err_beats;
    @(negedge clk);
    d0 = dma_cnt;
    check(req_ready == 1, "R1", "ready before request", 64'(req_ready), 1);
    req_valid = 1; req_write = wr; req_vaddr = va; req_gid = g; req_np = NP_W'(np); req_seq = seq;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R1", "ready after accept", 64'(req_ready), 0);
    check(!dma_req_valid && !rsp_valid, "R2", "output during lookup", 64'({dma_req_valid, rsp_valid}), 0);
    @(negedge clk);
    check(dma_req_valid || rsp_valid, "R2", "lookup done after one cycle", 64'({dma_req_valid, rsp_valid}), 1);
    k = 0; guard = 0; err_beats = 0;
    while (k < exp_beats && guard < 20000) begin
      guard++;
      rsp_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
      if (rsp_valid && rsp_ready) begin
        if (rsp_seq != seq) begin
          err_beats++;
          check(0, "R6", "sequence tag", 64'(rsp_seq), 64'(seq));
        end
        if (rsp_status != exp_st) begin
          err_beats++;
          check(0, (wr ? "R7" : (np == 0 ? "R9" : (exp_st == 2'b01 ? "R8" : "R5"))),
                "status", 64'(rsp_status), 64'(exp_st));
        end
        if (rsp_last != (k == exp_beats - 1)) begin
          err_beats++;
          check(0, "R5", "last flag", 64'(rsp_last), 64'(k == exp_beats - 1));
        end
        if (exp_st == 2'b00 && rsp_data != mk_data(va + VA_W'(k * 64), exp_lid)) begin
          err_beats++;
          check(0, "R4", "beat data/address", rsp_data[63:0], mk_data(va + VA_W'(k * 64), exp_lid) >> 0);
        end
        if (exp_st != 2'b00 && rsp_data != '0) begin
          err_beats++;
          check(0, "R8", "error beat data", rsp_data[63:0], 0);
        end
        if (k < exp_beats - 1 && req_ready) begin
          err_beats++;
          check(0, "R1", "ready while draining", 64'(req_ready), 0);
        end
        k++;
      end
      @(negedge clk);
    end
    rsp_ready = 0;
    check(err_beats == 0, req, "all beats matched", 64'(err_beats), 0);
    check(k == exp_beats, "R5", "beat count", 64'(k), 64'(exp_beats));
    check(req_ready == 1 && !rsp_valid, "R1", "idle after drain", 64'({req_ready, rsp_valid}), 64'b10);
    check(dma_cnt - d0 == exp_beats * (exp_st == 2'b00 ? 1 : 0), req, "memory reads issued",
          64'(dma_cnt - d0), 64'(exp_st == 2'b00 ? exp_beats : 0));
  endtask

  task automatic t_reset();
    check(req_ready == 1, "R11", "ready after reset", 64'(req_ready), 1);
    check(rsp_valid == 0, "R11", "rsp_valid after reset", 64'(rsp_valid), 0);
    check(dma_req_valid == 0, "R11", "dma valid after reset", 64'(dma_req_valid), 0);
    run_req("R11", 0, 48'h1000, 8'h00, 1, 16'h0001, 2'b01, 0);
    run_req("R11", 0, 48'h2000, 8'h5a, 1, 16'h0002, 2'b01, 0);
  endtask

  task automatic t_single_page();
    tbl_write(3, 1, 8'h21, 8'h07);
    run_req("R2", 0, 48'h0000_1000_1000, 8'h21, 1, 16'h1234, 2'b00, 8'h07);
  endtask

  task automatic t_multi_page_bp();
    slow_mem = 1; bp_mode = 1;
    tbl_write(15, 1, 8'hc3, 8'h9e);
    run_req("R10", 0, 48'h7fff_0000_0000, 8'hc3, 3, 16'hbeef, 2'b00, 8'h9e);
    slow_mem = 0; bp_mode = 0;
  endtask

  task automatic t_write_op();
    run_req("R7", 1, 48'h3000, 8'h21, 1, 16'h0777, 2'b10, 0);
  endtask

  task automatic t_zero_len();
    run_req("R9", 0, 48'h4000, 8'h21, 0, 16'h0888, 2'b11, 0);
    run_req("R9", 1, 48'h4000, 8'hee, 0, 16'h0889, 2'b10, 0);
    run_req("R9", 0, 48'h4000, 8'hee, 0, 16'h088a, 2'b11, 0);
  endtask

  task automatic t_unknown();
    run_req("R8", 0, 48'h5000, 8'h22, 2, 16'hffff, 2'b01, 0);
  endtask

  task automatic t_dup_remove();
    tbl_write(2, 1, 8'h40, 8'h33);
    tbl_write(9, 1, 8'h40, 8'h44);
    run_req("R3", 0, 48'h6000, 8'h40, 1, 16'h0010, 2'b00, 8'h33);
    tbl_write(2, 0, 8'h40, 8'h33);
    run_req("R3", 0, 48'h6000, 8'h40, 1, 16'h0011, 2'b00, 8'h44);
    tbl_write(9, 0, 8'h40, 8'h44);
    run_req("R3", 0, 48'h6000, 8'h40, 1, 16'h0012, 2'b01, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_page();
    t_write_op();
    t_zero_len();
    t_unknown();
    t_multi_page_bp();
    t_dup_remove();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule